// File: doc/BRIEF.md
# Vectored Interrupt Controller

The controller gathers a parameterised set of interrupt request lines (32 by default) and presents a single level-sensitive request to a processor. Each line is brought into the clock domain by a two-stage synchroniser and then combined with a register of software-raised requests. A per-source enable set decides which of these requests may interrupt. When the controller is idle and globally enabled, it captures the lowest-numbered enabled pending source and drives its output active. The output stays active until software signals completion.

Software takes the interrupt by reading one register. That read returns the programmable 32-bit word stored for the captured source in a table of per-source words. Software finishes by writing any value to the completion register. That write clears the software-raised request of the captured source and frees the controller, which looks at the remaining requests again on the next cycle. The enable set is changed through a separate set port and a separate clear port, so no read-modify-write is needed. The active level of the output is chosen by a control bit.

Access is through a plain register port with a word address, write enable, read enable and 32-bit data. Read data appears one cycle after the read strobe.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the control word, enable set and software-raised requests are all zero, no source is captured, `rdata` is zero, and `irq_out` is high, which is the inactive level for polarity 0.
- R2: Control word (word address 0): bit 0 is the global enable and bit 1 is the polarity. Polarity 1 means active high and polarity 0 means active low. While bit 0 is 0, no source is captured and `irq_out` sits at its inactive level.
- R3: A write to word 2 sets every enable bit whose data bit is 1. A write to word 3 clears every enable bit whose data bit is 1. Data bits that are 0 change nothing. Word 4 reads back the current enable set.
- R4: Word 1 reads the unmasked pending state, which is the synchronised input OR the software-raised requests. A change on `irq_in` reaches this state after two clock edges.
- R5: Word 6 holds the software-raised requests. A write replaces it, a read returns it, and each set bit acts as a pending request for its source.
- R6: When the controller is idle and enabled and at least one enabled source is pending, it captures the lowest-numbered such source at the next edge and `irq_out` goes active.
- R7: Reading word 5 returns the table word of the captured source, or zero when no source is captured.
- R8: Once a source is captured, `irq_out` stays active even if the request goes away, until any write to word 7. That write releases the output and clears the software-raised bit of the captured source. Remaining pending sources are evaluated on the following cycle.
- R9: Words 32 to 63 (byte offsets 0x80 to 0xFC) are the per-source table, one entry per source in source order. Each entry is fully writable and readable as 32 bits.
- R10: `rdata` updates only in the cycle after `rd_en` and holds its value otherwise. Words 2, 3, 7 and unmapped words 8 to 31 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_in | input | NUM_SRC | Asynchronous request lines, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, one cycle after `rd_en` |
| irq_out | output | 1 | Processor interrupt request, polarity set by control bit 1 |

## Verification
A wrong captured index shows up at once in the word returned by the vector read. That word is a distinct table value per source, so a priority or capture error is visible on the first read after `irq_out` goes active. A stale busy flag shows as `irq_out` staying active after a completion write, one cycle later, or as a second pending source never being served. A corrupted enable set appears in the readback of word 4 and as a missing or spurious capture two cycles after a software raise.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

    // control word: en is bit 0, pol is bit 1
    typedef struct packed {
        logic pol;
        logic en;
    } ctl_t;

    localparam int REG_CTL  = 0;
    localparam int REG_RAW  = 1;
    localparam int REG_SET  = 2;
    localparam int REG_CLR  = 3;
    localparam int REG_MASK = 4;
    localparam int REG_VEC  = 5;
    localparam int REG_TRIG = 6;
    localparam int REG_EOI  = 7;
    localparam int TBL_BASE = 32;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= '0;
                else        chain_q[g] <= chain_d[g];
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int WIDTH = 32,
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic [WIDTH-1:0] req,
    output logic             valid,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (req[i]) begin
                valid = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_vec_table.sv
module irq_vec_table #(
    parameter int DEPTH = 32,
    parameter int DW    = 32,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [DW-1:0]    wdata,
    input  logic [IDX_W-1:0] ridx_a,
    output logic [DW-1:0]    rdata_a,
    input  logic [IDX_W-1:0] ridx_b,
    output logic [DW-1:0]    rdata_b
);
    logic [DW-1:0] entry_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) entry_q[widx] <= wdata;
    end

    assign rdata_a = (int'(ridx_a) < DEPTH) ? entry_q[ridx_a] : '0;
    assign rdata_b = (int'(ridx_b) < DEPTH) ? entry_q[ridx_b] : '0;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_vec_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int DW      = 32,
    parameter int ADDR_W  = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DW-1:0]      wdata,
    output logic [DW-1:0]      rdata,
    output logic               irq_out
);
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    typedef struct packed {
        ctl_t               ctl;
        logic [NUM_SRC-1:0] mask;
        logic [NUM_SRC-1:0] trig;
        logic               busy;
        logic [IDX_W-1:0]   cur;
        logic [DW-1:0]      rdata;
    } state_t;

    state_t s_d, s_q;

    logic [NUM_SRC-1:0] sync_irq;
    logic [NUM_SRC-1:0] raw;
    logic [NUM_SRC-1:0] pend;
    logic               pick_valid;
    logic [IDX_W-1:0]   pick_idx;
    logic [ADDR_W-1:0]  tbl_off;
    logic               tbl_hit;
    logic [DW-1:0]      tbl_rd;
    logic [DW-1:0]      vec_rd;
    logic               eoi_wr;
    logic               active;

    irq_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (irq_in),
        .sync_out (sync_irq)
    );

    assign raw  = sync_irq | s_q.trig;
    assign pend = raw & s_q.mask;

    irq_pick #(.WIDTH(NUM_SRC)) u_pick (
        .req   (pend),
        .valid (pick_valid),
        .idx   (pick_idx)
    );

    assign tbl_off = addr - ADDR_W'(TBL_BASE);
    assign tbl_hit = (addr >= ADDR_W'(TBL_BASE)) && (tbl_off < ADDR_W'(NUM_SRC));

    irq_vec_table #(.DEPTH(NUM_SRC), .DW(DW)) u_table (
        .clk     (clk),
        .we      (wr_en && tbl_hit),
        .widx    (tbl_off[IDX_W-1:0]),
        .wdata   (wdata),
        .ridx_a  (tbl_off[IDX_W-1:0]),
        .rdata_a (tbl_rd),
        .ridx_b  (s_q.cur),
        .rdata_b (vec_rd)
    );

    assign eoi_wr = wr_en && (addr == ADDR_W'(REG_EOI));

    always_comb begin
        s_d = s_q;

        if (wr_en) begin
            case (addr)
                ADDR_W'(REG_CTL):  s_d.ctl  = ctl_t'(wdata[1:0]);
                ADDR_W'(REG_SET):  s_d.mask = s_q.mask | wdata[NUM_SRC-1:0];
                ADDR_W'(REG_CLR):  s_d.mask = s_q.mask & ~wdata[NUM_SRC-1:0];
                ADDR_W'(REG_TRIG): s_d.trig = wdata[NUM_SRC-1:0];
                default: ;
            endcase
        end

        if (eoi_wr) begin
            if (s_q.busy) s_d.trig[s_q.cur] = 1'b0;
            s_d.busy = 1'b0;
        end else if (!s_q.busy && s_q.ctl.en && pick_valid) begin
            s_d.busy = 1'b1;
            s_d.cur  = pick_idx;
        end

        if (rd_en) begin
            case (addr)
                ADDR_W'(REG_CTL):  s_d.rdata = DW'({s_q.ctl.pol, s_q.ctl.en});
                ADDR_W'(REG_RAW):  s_d.rdata = DW'(raw);
                ADDR_W'(REG_MASK): s_d.rdata = DW'(s_q.mask);
                ADDR_W'(REG_VEC):  s_d.rdata = s_q.busy ? vec_rd : '0;
                ADDR_W'(REG_TRIG): s_d.rdata = DW'(s_q.trig);
                default:           s_d.rdata = tbl_hit ? tbl_rd : '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active  = s_q.busy && s_q.ctl.en;
    assign irq_out = s_q.ctl.pol ? active : ~active;
    assign rdata   = s_q.rdata;

    function automatic logic is_lowest(input logic [NUM_SRC-1:0] v, input logic [IDX_W-1:0] k);
        logic r;
        r = v[k];
        for (int i = 0; i < NUM_SRC; i++) begin
            if (i < int'(k) && v[i]) r = 1'b0;
        end
        return r;
    endfunction

    // R2: disabled controller keeps the output at the inactive level
    a_r2_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.ctl.en |-> (irq_out == !s_q.ctl.pol));

    // R3: set port sets every written one
    a_r3_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(REG_SET)) |=>
        ((s_q.mask & $past(wdata[NUM_SRC-1:0])) == $past(wdata[NUM_SRC-1:0])));

    // R3: clear port clears every written one
    a_r3_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(REG_CLR)) |=>
        ((s_q.mask & $past(wdata[NUM_SRC-1:0])) == '0));

    // R6: capture happens and picks the lowest enabled pending source
    a_r6_lowest_pick: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.busy && s_q.ctl.en && !eoi_wr && (|pend)) |=>
        (s_q.busy && is_lowest($past(pend), s_q.cur)));

    // R8: captured source held until completion write
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !eoi_wr) |=> (s_q.busy && $stable(s_q.cur)));

    // R8: completion write releases the controller
    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_wr |=> !s_q.busy);

    // R10: read data only moves after a read strobe
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_in = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [5:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_vector_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
    );

    localparam int NV = 7;
    localparam logic [31:0] T_MASK [NV] = '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_FF00,
        32'h0000_0000, 32'h8000_0001, 32'hFFFF_0000, 32'h00C0_0000};
    localparam logic [31:0] T_TRIG [NV] = '{32'h0000_0001, 32'h8000_0000, 32'h00F0_F0F0,
        32'hFFFF_FFFF, 32'h8000_0000, 32'h0000_FFFF, 32'h00E0_0000};
    localparam int T_EXP [NV] = '{0, 31, 12, -1, 31, -1, 22};

    function automatic logic [31:0] vec_of(input int i);
        return 32'hC0DE_0000 ^ (32'(i) * 32'h0001_0203);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        addr = 6'(a); wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        addr = 6'(a); rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic cleanup();
        wr(6, 32'h0);
        wr(3, 32'hFFFF_FFFF);
        wr(7, 32'h0);
        cyc(1);
    endtask

    initial begin
        int cnt = 0;
        while (!done && cnt < 50000) begin
            @(posedge clk);
            cnt++;
        end
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=done", cnt);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R1 reset state
        chk("R1 irq_out", 32'(irq_out), 32'd1);
        chk("R1 rdata", rdata, 32'h0);
        rd(0, d); chk("R1 ctl", d, 32'h0);
        rd(4, d); chk("R1 mask", d, 32'h0);
        rd(5, d); chk("R1 vector", d, 32'h0);
        rd(6, d); chk("R1 trig", d, 32'h0);

        // R9 program and read back the table
        for (int i = 0; i < N; i++) wr(32 + i, vec_of(i));
        for (int i = 0; i < N; i++) begin
            rd(32 + i, d); chk("R9 table", d, vec_of(i));
        end

        // R2 control readback, then enabled active-high for the table walk
        wr(0, 32'h3);
        rd(0, d); chk("R2 ctl readback", d, 32'h3);

        // vector table walk (R6 R7 R5 R4)
        for (int k = 0; k < NV; k++) begin
            cleanup();
            wr(2, T_MASK[k]);
            wr(6, T_TRIG[k]);
            cyc(2);
            chk("R6 irq_out", 32'(irq_out), (T_EXP[k] >= 0) ? 32'd1 : 32'd0);
            rd(5, d); chk("R7 vector", d, (T_EXP[k] >= 0) ? vec_of(T_EXP[k]) : 32'h0);
            rd(1, d); chk("R4 raw", d, T_TRIG[k]);
            rd(6, d); chk("R5 trig readback", d, T_TRIG[k]);
        end
        cleanup();

        // R3 set/clear ports
        wr(2, 32'h0000_00F0); rd(4, d); chk("R3 set", d, 32'h0000_00F0);
        wr(2, 32'h0000_0F00); rd(4, d); chk("R3 set more", d, 32'h0000_0FF0);
        wr(3, 32'h0000_0030); rd(4, d); chk("R3 clear", d, 32'h0000_0FC0);
        wr(3, 32'h0);         rd(4, d); chk("R3 clear zero", d, 32'h0000_0FC0);
        wr(2, 32'h0);         rd(4, d); chk("R3 set zero", d, 32'h0000_0FC0);
        cleanup();

        // R4 R8 hardware input held after request drops
        wr(2, 32'h0000_0100);
        irq_in = 32'h0000_0100;
        cyc(2);
        rd(1, d); chk("R4 raw from input", d, 32'h0000_0100);
        cyc(1);
        chk("R8 irq_out active", 32'(irq_out), 32'd1);
        irq_in = '0;
        cyc(5);
        chk("R8 irq_out held", 32'(irq_out), 32'd1);
        rd(5, d); chk("R8 vector held", d, vec_of(8));
        wr(7, 32'h0);
        chk("R8 released", 32'(irq_out), 32'd0);
        cyc(2);
        chk("R8 stays released", 32'(irq_out), 32'd0);
        cleanup();

        // R8 re-evaluation after completion
        wr(2, 32'h88);
        wr(6, 32'h88);
        cyc(2);
        rd(5, d); chk("R8 first vector", d, vec_of(3));
        wr(7, 32'h0);
        cyc(2);
        chk("R8 second irq", 32'(irq_out), 32'd1);
        rd(5, d); chk("R8 second vector", d, vec_of(7));
        rd(6, d); chk("R8 trig bit cleared", d, 32'h80);
        wr(7, 32'h0);
        cyc(2);
        chk("R8 all served", 32'(irq_out), 32'd0);
        rd(6, d); chk("R8 trig empty", d, 32'h0);
        cleanup();

        // R2 global enable and polarity
        wr(0, 32'h2);
        wr(2, 32'h20);
        wr(6, 32'h20);
        cyc(3);
        chk("R2 disabled pol1", 32'(irq_out), 32'd0);
        rd(5, d); chk("R2 nothing captured", d, 32'h0);
        wr(0, 32'h0);
        chk("R2 disabled pol0", 32'(irq_out), 32'd1);
        wr(0, 32'h1);
        cyc(2);
        chk("R2 active low", 32'(irq_out), 32'd0);
        rd(5, d); chk("R2 vector after enable", d, vec_of(5));
        cleanup();
        chk("R2 idle low polarity", 32'(irq_out), 32'd1);

        // R9 overwrite one entry
        wr(32 + 17, 32'h1234_ABCD);
        rd(32 + 17, d); chk("R9 overwrite", d, 32'h1234_ABCD);
        rd(32 + 16, d); chk("R9 neighbour", d, vec_of(16));

        // R10 unmapped and write-only words, rdata hold
        rd(8, d);  chk("R10 unmapped 8", d, 32'h0);
        rd(31, d); chk("R10 unmapped 31", d, 32'h0);
        rd(2, d);  chk("R10 set port reads 0", d, 32'h0);
        rd(32 + 17, d);
        cyc(4);
        chk("R10 rdata holds", rdata, 32'h1234_ABCD);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule